// File: doc/BRIEF.md
# Error Interrupt Status and Clear Unit

This unit collects the error conditions and DMA-completion events of an external memory interface controller and turns them into a single interrupt request. Three error sources are tracked as sticky flags: a transaction held by the not-ready condition for longer than a programmable wait limit, a read stalled behind pending writes, and a write stalled because the write FIFO is full. The two stall errors are recorded only while their enables are on. The timeout comes from an internal hold counter, and a wait limit of zero disables it.

Software reaches the unit through a small register bus with two words: a status/clear word and a mask word. A single raw error flag stands for the error group. The raw error flag and the two DMA-done flags are combined with the mask to produce the masked status and the interrupt line. Writing a 1 to any error bit of the status word clears that bit, the raw error flag and the error enable in the mask, so the handler has to re-arm the interrupt on purpose. Bus writes reach the register state one cycle after they are presented. A read issued in the cycle right after a write therefore still returns the old contents.

Top module: `errirq_unit`

## Requirements
- R1: After synchronous reset all error flags, raw status bits, mask bits and read data are 0 and `irq` is low.
- R2: A status-word read (`bus_sel`=0) returns the timeout flag in bit 0, the read-stall flag in bit 1 and the write-full flag in bit 2. Bits 3, 4 and every higher bit read as 0.
- R3: The write-full flag is set by `ev_wfull` only when `en_wfull` is 1, and the read-stall flag is set by `ev_rstall` only when `en_rstall` is 1. A flag set in cycle N reads as 1 from cycle N+1.
- R4: The timeout flag sets once `xfer_hold` has been high for `max_wait`+1 consecutive cycles. It fires at most once per hold. The count restarts whenever `xfer_hold` drops, and it never fires while `max_wait` is 0.
- R5: Writing 1 to a status bit in 2:0 clears that flag and writing 0 leaves it unchanged. If a new event for a flag arrives in the same cycle that its clear takes effect, the flag stays 1.
- R6: Any status-word write with a 1 in bits 2:0 also clears the raw error flag (`raw_status[0]`) and the error enable (mask bit 0).
- R7: `raw_status[0]` becomes 1 in the cycle after any error flag is set.
- R8: `dma_rd_done` sets `raw_status[1]` and `dma_wr_done` sets `raw_status[2]`. Writing 1 to status bit 3 clears `raw_status[1]`, and writing 1 to status bit 4 clears `raw_status[2]`. A done pulse in the cycle the clear takes effect wins.
- R9: The mask word (`bus_sel`=1) holds bit 0 error enable, bit 1 DMA-read enable and bit 2 DMA-write enable. It is readable and writable, and its higher bits read as 0.
- R10: `masked_status` equals `raw_status` AND mask, and `irq` is high exactly when any masked bit is 1.
- R11: A write presented in cycle N takes effect at the end of cycle N+1. A read in cycle N+1 returns the contents from before the write, and a read in cycle N+2 or later returns the new contents. Read data appears on `bus_rdata` the cycle after `bus_rd` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Word select: 0 status/clear, 1 mask |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| ev_wfull | input | 1 | Write stalled on full write FIFO |
| en_wfull | input | 1 | Enable for the write-full error |
| ev_rstall | input | 1 | Read stalled behind pending writes |
| en_rstall | input | 1 | Enable for the read-stall error |
| xfer_hold | input | 1 | Not-ready condition holding a transaction |
| max_wait | input | WAIT_W | Hold limit in cycles, 0 disables timeout |
| dma_rd_done | input | 1 | DMA read completion pulse |
| dma_wr_done | input | 1 | DMA write completion pulse |
| raw_status | output | 3 | {DMA write, DMA read, error} raw flags |
| masked_status | output | 3 | raw_status AND mask |
| irq | output | 1 | Interrupt request |

## Verification
Directed sequences first separate gated from ungated stall events and writes of 0 from writes of 1. A clear is timed to land on a fresh event, which shows whether set takes priority. Hold runs of exactly `max_wait` and `max_wait`+1 cycles locate the timeout threshold, and a long hold with a limit of zero confirms the disable. A read placed directly behind a write, and a second read after it, expose the one-cycle write latency. A seeded random phase then mixes overlapping events, clears, mask writes, hold bursts and changing limits, and every output is compared each cycle with a reference model built from the requirements.

// File: rtl/errirq_pkg.sv
package errirq_pkg;

    localparam int ERR_N   = 3;
    localparam int IRQ_N   = 3;
    localparam int DMA_N   = 2;
    localparam int FIELD_W = ERR_N + DMA_N;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_MASK   = 1'b1
    } sel_e;

    // error flags, bit 0 timeout, bit 1 read stall, bit 2 write full
    typedef struct packed {
        logic wfull;
        logic rstall;
        logic tout;
    } err_t;

    // interrupt sources, bit 0 error group, bit 1 dma read, bit 2 dma write
    typedef struct packed {
        logic dma_wr;
        logic dma_rd;
        logic err;
    } irq_t;

    // registered bus write waiting to be applied
    typedef struct packed {
        logic                 vld;
        sel_e                 sel;
        logic [FIELD_W-1:0]   bits;
    } wr_req_t;

    function automatic logic [ERR_N-1:0] err_clear(input wr_req_t r);
        return (r.vld && r.sel == SEL_STATUS) ? r.bits[ERR_N-1:0] : '0;
    endfunction

    function automatic logic [DMA_N-1:0] dma_clear(input wr_req_t r);
        return (r.vld && r.sel == SEL_STATUS) ? r.bits[FIELD_W-1:ERR_N] : '0;
    endfunction

    function automatic logic mask_load(input wr_req_t r);
        return r.vld && r.sel == SEL_MASK;
    endfunction

endpackage

// File: rtl/errirq_tout.sv
module errirq_tout #(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic [WAIT_W-1:0] max_wait,
    output logic              fire
);
    logic [WAIT_W-1:0] cnt_q;
    logic              done_q;
    logic              limit_on;

    assign limit_on = (max_wait != '0);
    // cnt_q holds the number of earlier held cycles of this hold
    assign fire = hold && !done_q && limit_on && (cnt_q >= max_wait);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!hold) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (fire) begin
                done_q <= 1'b1;
            end else if (cnt_q != '1) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/errirq_bus.sv
module errirq_bus
    import errirq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  sel_e              sel,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    input  err_t              err_flags,
    input  irq_t              mask,
    output logic [DATA_W-1:0] rdata,
    output wr_req_t           req
);
    logic [DATA_W-1:0] rd_word;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[DATA_W-1:FIELD_W];

    always_comb begin
        rd_word = '0;
        case (sel)
            SEL_STATUS: rd_word[ERR_N-1:0] = err_flags;
            default:    rd_word[IRQ_N-1:0] = mask;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req   <= '0;
            rdata <= '0;
        end else begin
            req.vld  <= wr;
            req.sel  <= sel;
            req.bits <= wdata[FIELD_W-1:0];
            if (rd) begin
                rdata <= rd_word;
            end
        end
    end
endmodule

// File: rtl/errirq_state.sv
module errirq_state
    import errirq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t req,
    input  err_t    set_err,
    input  logic    dma_rd_done,
    input  logic    dma_wr_done,
    output err_t    err_q,
    output irq_t    raw,
    output irq_t    mask
);
    logic [ERR_N-1:0] flag_q;
    logic [ERR_N-1:0] set_vec;
    logic [ERR_N-1:0] clr_vec;
    logic [DMA_N-1:0] dma_q;
    logic [DMA_N-1:0] done_vec;
    logic [DMA_N-1:0] dclr_vec;
    logic             raw_err_q;
    logic             err_clr_any;
    logic [IRQ_N-1:0] mask_q;

    assign set_vec     = set_err;
    assign clr_vec     = err_clear(req);
    assign dclr_vec    = dma_clear(req);
    assign done_vec    = {dma_wr_done, dma_rd_done};
    assign err_clr_any = |clr_vec;

    genvar gi;
    generate
        for (gi = 0; gi < ERR_N; gi++) begin : g_err
            always_ff @(posedge clk) begin
                if (rst) flag_q[gi] <= 1'b0;
                else     flag_q[gi] <= (flag_q[gi] & ~clr_vec[gi]) | set_vec[gi];
            end
        end
        for (gi = 0; gi < DMA_N; gi++) begin : g_dma
            always_ff @(posedge clk) begin
                if (rst) dma_q[gi] <= 1'b0;
                else     dma_q[gi] <= (dma_q[gi] & ~dclr_vec[gi]) | done_vec[gi];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_err_q <= 1'b0;
            mask_q    <= '0;
        end else begin
            raw_err_q <= (raw_err_q & ~err_clr_any) | (|set_vec);
            if (mask_load(req)) begin
                mask_q <= req.bits[IRQ_N-1:0];
            end else if (err_clr_any) begin
                mask_q[0] <= 1'b0;
            end
        end
    end

    assign err_q = err_t'(flag_q);
    assign raw   = irq_t'({dma_q, raw_err_q});
    assign mask  = irq_t'(mask_q);
endmodule

// File: rtl/errirq_unit.sv
module errirq_unit
    import errirq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ev_wfull,
    input  logic              en_wfull,
    input  logic              ev_rstall,
    input  logic              en_rstall,
    input  logic              xfer_hold,
    input  logic [WAIT_W-1:0] max_wait,
    input  logic              dma_rd_done,
    input  logic              dma_wr_done,
    output logic [2:0]        raw_status,
    output logic [2:0]        masked_status,
    output logic              irq
);
    wr_req_t          req;
    err_t             err_s;
    err_t             set_err;
    irq_t             raw_s;
    irq_t             mask_s;
    logic             tout_fire;
    logic [ERR_N-1:0] err_flags;
    logic [IRQ_N-1:0] mask_bits;

    errirq_tout #(.WAIT_W(WAIT_W)) u_tout (
        .clk      (clk),
        .rst      (rst),
        .hold     (xfer_hold),
        .max_wait (max_wait),
        .fire     (tout_fire)
    );

    assign set_err.wfull  = ev_wfull & en_wfull;
    assign set_err.rstall = ev_rstall & en_rstall;
    assign set_err.tout   = tout_fire;

    errirq_bus #(.DATA_W(DATA_W)) u_bus (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel_e'(bus_sel)),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .wdata     (bus_wdata),
        .err_flags (err_s),
        .mask      (mask_s),
        .rdata     (bus_rdata),
        .req       (req)
    );

    errirq_state u_state (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .set_err     (set_err),
        .dma_rd_done (dma_rd_done),
        .dma_wr_done (dma_wr_done),
        .err_q       (err_s),
        .raw         (raw_s),
        .mask        (mask_s)
    );

    assign err_flags     = err_s;
    assign mask_bits     = mask_s;
    assign raw_status    = raw_s;
    assign masked_status = raw_s & mask_s;
    assign irq           = |masked_status;
endmodule

// File: rtl/errirq_unit_chk.sv
module errirq_unit_chk #(
    parameter int DATA_W = 32,
    parameter int WAIT_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              ev_wfull,
    input logic              en_wfull,
    input logic              ev_rstall,
    input logic              en_rstall,
    input logic [WAIT_W-1:0] max_wait,
    input logic              dma_rd_done,
    input logic              dma_wr_done,
    input logic [2:0]        raw_status,
    input logic              irq,
    input logic [2:0]        err_flags,
    input logic [2:0]        mask_bits
);
    p_hi_zero_r2: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DATA_W-1:3] == '0);

    p_wfull_set_r3: assert property (@(posedge clk) disable iff (rst)
        (ev_wfull && en_wfull) |=> err_flags[2]);

    p_wfull_gate_r3: assert property (@(posedge clk) disable iff (rst)
        (!err_flags[2] && !(ev_wfull && en_wfull)) |=> !err_flags[2]);

    p_tout_off_r4: assert property (@(posedge clk) disable iff (rst)
        (max_wait == '0 && !err_flags[0]) |=> !err_flags[0]);

    p_clear_mask_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_sel && (|bus_wdata[2:0])) |=> ##1 !mask_bits[0]);

    p_raw_err_r7: assert property (@(posedge clk) disable iff (rst)
        (ev_rstall && en_rstall) |=> raw_status[0]);

    p_dma_rd_r8: assert property (@(posedge clk) disable iff (rst)
        dma_rd_done |=> raw_status[1]);

    p_dma_wr_r8: assert property (@(posedge clk) disable iff (rst)
        dma_wr_done |=> raw_status[2]);

    p_quiet_irq_r10: assert property (@(posedge clk) disable iff (rst)
        (raw_status == 3'b000) |-> !irq);
endmodule

bind errirq_unit errirq_unit_chk #(.DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .ev_wfull    (ev_wfull),
    .en_wfull    (en_wfull),
    .ev_rstall   (ev_rstall),
    .en_rstall   (en_rstall),
    .max_wait    (max_wait),
    .dma_rd_done (dma_rd_done),
    .dma_wr_done (dma_wr_done),
    .raw_status  (raw_status),
    .irq         (irq),
    .err_flags   (err_flags),
    .mask_bits   (mask_bits)
);

// File: tb/errirq_unit_bench.sv
module errirq_unit_bench;
    localparam int DATA_W = 32;
    localparam int WAIT_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              ev_wfull = 1'b0;
    logic              en_wfull = 1'b0;
    logic              ev_rstall = 1'b0;
    logic              en_rstall = 1'b0;
    logic              xfer_hold = 1'b0;
    logic [WAIT_W-1:0] max_wait = '0;
    logic              dma_rd_done = 1'b0;
    logic              dma_wr_done = 1'b0;
    logic [2:0]        raw_status;
    logic [2:0]        masked_status;
    logic              irq;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    // reference model state
    logic [2:0]        m_err, m_raw, m_mask;
    logic              m_pv, m_psel;
    logic [4:0]        m_pbits;
    logic [WAIT_W-1:0] m_cnt;
    logic              m_done;
    logic [DATA_W-1:0] m_rdata;

    always #10 clk = ~clk;

    errirq_unit #(.DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_errirq_unit (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_wfull(ev_wfull),
        .en_wfull(en_wfull), .ev_rstall(ev_rstall), .en_rstall(en_rstall),
        .xfer_hold(xfer_hold), .max_wait(max_wait), .dma_rd_done(dma_rd_done),
        .dma_wr_done(dma_wr_done), .raw_status(raw_status),
        .masked_status(masked_status), .irq(irq)
    );

    task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [DATA_W-1:0] rd_word(input logic sel);
        logic [DATA_W-1:0] w = '0;
        w[2:0] = sel ? m_mask : m_err;
        return w;
    endfunction

    task automatic model_reset();
        m_err = '0; m_raw = '0; m_mask = '0; m_pv = 0; m_psel = 0; m_pbits = '0;
        m_cnt = '0; m_done = 0; m_rdata = '0;
    endtask

    // one clock: model follows the requirements, outputs compared at negedge
    task automatic cycle();
        logic       fire;
        logic [2:0] setv, clr;
        logic [1:0] dclr;
        @(posedge clk);
        fire = xfer_hold && !m_done && (max_wait != 0) && (m_cnt >= max_wait);  // R4
        setv = {ev_wfull & en_wfull, ev_rstall & en_rstall, fire};             // R3
        clr  = (m_pv && !m_psel) ? m_pbits[2:0] : 3'b000;                      // R5
        dclr = (m_pv && !m_psel) ? m_pbits[4:3] : 2'b00;                       // R8
        if (bus_rd) m_rdata = rd_word(bus_sel);                                // R11
        m_raw[0] = (m_raw[0] & ~(|clr)) | (|setv);                             // R6 R7
        m_raw[1] = (m_raw[1] & ~dclr[0]) | dma_rd_done;
        m_raw[2] = (m_raw[2] & ~dclr[1]) | dma_wr_done;
        if (m_pv && m_psel) m_mask = m_pbits[2:0];                             // R9
        else if (|clr) m_mask[0] = 1'b0;
        m_err = (m_err & ~clr) | setv;
        if (!xfer_hold) begin m_cnt = '0; m_done = 0; end
        else if (!m_done) begin
            if (fire) m_done = 1;
            else if (m_cnt != '1) m_cnt = m_cnt + 1'b1;
        end
        m_pv = bus_wr; m_psel = bus_sel; m_pbits = bus_wdata[4:0];
        @(negedge clk);
        chk("R11 read data", bus_rdata, m_rdata);
        chk("R8 raw status", {29'b0, raw_status}, {29'b0, m_raw});
        chk("R10 masked status", {29'b0, masked_status}, {29'b0, m_raw & m_mask});
        chk("R10 irq", {31'b0, irq}, {31'b0, |(m_raw & m_mask)});
    endtask

    task automatic wr(input logic sel, input logic [DATA_W-1:0] d);
        bus_wr = 1; bus_sel = sel; bus_wdata = d;
        cycle();
        bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic rd(input logic sel);
        bus_rd = 1; bus_sel = sel;
        cycle();
        bus_rd = 0;
    endtask

    initial begin
        void'($urandom(32'd5721));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk("R1 raw after reset", {29'b0, raw_status}, 0);
        chk("R1 irq after reset", {31'b0, irq}, 0);
        rd(0); chk("R1 status after reset", bus_rdata, 0);

        // R9 / R11: mask write, read directly behind it returns old value
        wr(1, 32'hFFFF_FFFF);
        rd(1); chk("R11 read right after write is old", bus_rdata, 0);
        rd(1); chk("R9 mask readback", bus_rdata, 32'h7);

        // R3: gated and ungated write-full events
        en_wfull = 0; ev_wfull = 1; cycle(); ev_wfull = 0; cycle();
        rd(0); chk("R3 write-full ignored when disabled", bus_rdata, 0);
        en_wfull = 1; ev_wfull = 1; cycle(); ev_wfull = 0;
        chk("R7 raw error set", {31'b0, raw_status[0]}, 1);
        chk("R10 irq raised", {31'b0, irq}, 1);
        rd(0); chk("R2 R3 write-full in bit 2", bus_rdata, 32'h4);

        // R5 / R6: write 0 leaves, write 1 clears
        wr(0, 32'h0); cycle();
        rd(0); chk("R5 write of 0 keeps flag", bus_rdata, 32'h4);
        wr(0, 32'h4); cycle();
        rd(0); chk("R5 write of 1 clears flag", bus_rdata, 0);
        chk("R6 raw error cleared", {31'b0, raw_status[0]}, 0);
        rd(1); chk("R6 error enable cleared", bus_rdata, 32'h6);

        // R5: set wins over clear landing in the same cycle
        wr(1, 32'h7);
        en_rstall = 1;
        wr(0, 32'h2);
        ev_rstall = 1; cycle(); ev_rstall = 0;
        rd(0); chk("R5 set beats clear", bus_rdata, 32'h2);
        chk("R7 raw error kept by new event", {31'b0, raw_status[0]}, 1);

        // R4: threshold and disable
        wr(0, 32'h7); cycle();
        max_wait = 3; xfer_hold = 1;
        repeat (3) cycle();
        xfer_hold = 0; cycle();
        rd(0); chk("R4 hold of max_wait cycles no timeout", bus_rdata, 0);
        xfer_hold = 1;
        repeat (4) cycle();
        xfer_hold = 0; cycle();
        rd(0); chk("R4 hold of max_wait+1 cycles times out", bus_rdata, 32'h1);
        wr(0, 32'h1); cycle();
        max_wait = 0; xfer_hold = 1;
        repeat (40) cycle();
        xfer_hold = 0; cycle();
        rd(0); chk("R4 zero limit disables timeout", bus_rdata, 0);

        // R8: DMA done set and clear
        wr(1, 32'h7); cycle();
        dma_rd_done = 1; cycle(); dma_rd_done = 0;
        chk("R8 dma read raw", {31'b0, raw_status[1]}, 1);
        chk("R10 dma read masked", {31'b0, masked_status[1]}, 1);
        wr(0, 32'h8); cycle();
        chk("R8 dma read cleared", {31'b0, raw_status[1]}, 0);
        dma_wr_done = 1; cycle(); dma_wr_done = 0;
        chk("R8 dma write raw", {31'b0, raw_status[2]}, 1);
        wr(0, 32'h10); cycle();
        chk("R8 dma write cleared", {31'b0, raw_status[2]}, 0);

        // random phase against the model (R2..R11)
        for (int i = 0; i < 4000; i++) begin
            ev_wfull    = ($urandom % 8) == 0;
            ev_rstall   = ($urandom % 8) == 0;
            en_wfull    = ($urandom % 4) != 0;
            en_rstall   = ($urandom % 4) != 0;
            dma_rd_done = ($urandom % 10) == 0;
            dma_wr_done = ($urandom % 10) == 0;
            if (($urandom % 6) == 0) xfer_hold = ~xfer_hold;
            if (($urandom % 50) == 0) max_wait = WAIT_W'($urandom % 6);
            bus_sel   = $urandom % 2;
            bus_wr    = ($urandom % 5) == 0;
            bus_rd    = ($urandom % 3) == 0;
            bus_wdata = $urandom;
            cycle();
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule